// File: doc/BRIEF.md
# Region Translation and Attribute Checker

This block maps a 32-bit virtual address onto a physical address through a small table of eight fixed regions, each 512 MB wide. The three most significant address bits choose the region. Every region carries a virtual region number that cannot be changed, a physical region number that software can rewrite, and a 4-bit attribute code. The attribute code, together with the kind of access (instruction fetch, data load or data store), selects the access mode that the memory system should use. It also decides whether the access must raise an exception.

The lookup is purely combinational. The physical address, the resolved mode and the exception flag all appear in the same cycle as the request. Each entry's physical number and attribute can be rewritten through a single write port, and a separate read port returns them. The block holds no other state, so one copy can serve instruction fetches and a second copy can serve data accesses.

Top module: `region_xlate`

## Requirements
- R1: After a synchronous active-high reset, every entry `e` (0..7) reads back physical region number `e` and attribute code 2.
- R2: The virtual region number of entry `e` is fixed at `e`, which means `rd_vrn` always equals `rd_idx`. A request is always served by the entry whose index equals `req_vaddr[31:29]`, whatever physical numbers have been written.
- R3: `xl_paddr[31:29]` is the selected entry's physical region number, and `xl_paddr[28:0]` equals `req_vaddr[28:0]`.
- R4: Access kinds on `req_kind` are 0 = fetch, 1 = load, 2 = store and 3 = reserved. Mode codes on `xl_mode` are 0 = fault, 1 = cached, 2 = cached without allocation, 3 = bypass, 4 = guarded bypass, 5 = write-through, 6 = write-back, 7 = write-back without allocation and 8 = isolate. For a fetch, attributes 1, 3, 4 and 5 give cached, attribute 2 gives bypass, and attributes 0 and 6..15 give fault.
- R5: For a load, attribute 0 gives cached without allocation, and attributes 1, 4 and 5 give cached. Attribute 2 gives guarded bypass and attribute 14 gives isolate. Attributes 3, 6..13 and 15 give fault.
- R6: For a store, attributes 0 and 1 give write-through, attribute 2 gives bypass, and attribute 4 gives write-back. Attribute 5 gives write-back without allocation and attribute 14 gives isolate. Attributes 3, 6..13 and 15 give fault.
- R7: `xl_fault` is high in the same cycle as the request exactly when `xl_mode` is fault. A reserved access kind (3) always gives mode fault with `xl_fault` high.
- R8: A write with `wr_en` high updates entry `wr_idx` on the next rising edge. Lookups and reads in the cycle of the write still see the old contents, and lookups and reads from the following cycle see the new contents.
- R9: The read port returns the current physical number and attribute of entry `rd_idx`. Entries that are not written keep their contents.
- R10: Asserting reset after entries have been rewritten restores every entry to its identity mapping with attribute 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_vaddr | input | 32 | Virtual address of the request |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 reserved |
| xl_paddr | output | 32 | Translated physical address |
| xl_mode | output | 4 | Resolved access mode code |
| xl_fault | output | 1 | Access must raise an exception |
| wr_en | input | 1 | Entry update strobe |
| wr_idx | input | 3 | Entry to update |
| wr_ppn | input | 3 | New physical region number |
| wr_attr | input | 4 | New attribute code |
| rd_idx | input | 3 | Entry to read |
| rd_vrn | output | 3 | Fixed virtual region number of the entry being read |
| rd_ppn | output | 3 | Physical region number of the entry being read |
| rd_attr | output | 4 | Attribute code of the entry being read |

## Verification
The bench sweeps all sixteen attribute codes under each of the three access kinds. This catches a decoder that folds the store-only write-back without allocation into plain write-back, grants isolate to fetches, or lets a load of code 3 through where it must fault. It probes the write in the cycle of the write itself and again one cycle later. A design that bypasses the write data into the lookup, or that lands the write one cycle late, therefore shows the wrong region bits at one of the two sample points. It also remaps one region onto another region's physical number. A design that selects entries by physical number instead of by fixed virtual number then routes the request through the wrong entry. A mid-run reset must bring every rewritten entry back to identity with bypass.

// File: rtl/region_xlate_pkg.sv
package region_xlate_pkg;

    localparam int ATTR_W = 4;
    localparam int MODE_W = 4;
    localparam logic [ATTR_W-1:0] ATTR_RESET = 4'd2;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [MODE_W-1:0] {
        MODE_FAULT        = 4'd0,
        MODE_CACHED       = 4'd1,
        MODE_CACHED_NA    = 4'd2,
        MODE_BYPASS       = 4'd3,
        MODE_BYPASS_GUARD = 4'd4,
        MODE_WTHRU        = 4'd5,
        MODE_WBACK        = 4'd6,
        MODE_WBACK_NA     = 4'd7,
        MODE_ISOLATE      = 4'd8
    } mode_e;

    function automatic mode_e fetch_mode(input logic [ATTR_W-1:0] a);
        case (a)
            4'd1, 4'd3, 4'd4, 4'd5: return MODE_CACHED;
            4'd2:                   return MODE_BYPASS;
            default:                return MODE_FAULT;
        endcase
    endfunction

    function automatic mode_e load_mode(input logic [ATTR_W-1:0] a);
        case (a)
            4'd0:               return MODE_CACHED_NA;
            4'd1, 4'd4, 4'd5:   return MODE_CACHED;
            4'd2:               return MODE_BYPASS_GUARD;
            4'd14:              return MODE_ISOLATE;
            default:            return MODE_FAULT;
        endcase
    endfunction

    function automatic mode_e store_mode(input logic [ATTR_W-1:0] a);
        case (a)
            4'd0, 4'd1: return MODE_WTHRU;
            4'd2:       return MODE_BYPASS;
            4'd4:       return MODE_WBACK;
            4'd5:       return MODE_WBACK_NA;
            4'd14:      return MODE_ISOLATE;
            default:    return MODE_FAULT;
        endcase
    endfunction

endpackage

// File: rtl/region_table.sv
module region_table
    import region_xlate_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   wr_en,
    input  logic [IDX_W-1:0]                       wr_idx,
    input  logic [IDX_W-1:0]                       wr_ppn,
    input  logic [ATTR_W-1:0]                      wr_attr,
    output logic [(1<<IDX_W)-1:0][IDX_W-1:0]       ppn_q,
    output logic [(1<<IDX_W)-1:0][ATTR_W-1:0]      attr_q
);
    localparam int NUM_ENT = 1 << IDX_W;

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ppn_q[e]  <= IDX_W'(e);
                attr_q[e] <= ATTR_RESET;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                ppn_q[e]  <= wr_ppn;
                attr_q[e] <= wr_attr;
            end
        end
    end
endmodule

// File: rtl/region_lookup.sv
module region_lookup
    import region_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0]                      vaddr,
    input  logic [(1<<IDX_W)-1:0][IDX_W-1:0]       ppn_tab,
    input  logic [(1<<IDX_W)-1:0][ATTR_W-1:0]      attr_tab,
    output logic [ADDR_W-1:0]                      paddr,
    output logic [ATTR_W-1:0]                      attr
);
    localparam int NUM_ENT = 1 << IDX_W;
    localparam int OFF_W   = ADDR_W - IDX_W;

    logic [NUM_ENT-1:0] hit;
    logic [IDX_W-1:0]   sel_ppn;
    logic [ATTR_W-1:0]  sel_attr;

    // each entry compares its fixed virtual region number against the request
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
        assign hit[e] = (vaddr[ADDR_W-1 -: IDX_W] == IDX_W'(e));
    end

    always_comb begin
        sel_ppn  = '0;
        sel_attr = '0;
        for (int e = 0; e < NUM_ENT; e++) begin
            if (hit[e]) begin
                sel_ppn  = sel_ppn  | ppn_tab[e];
                sel_attr = sel_attr | attr_tab[e];
            end
        end
    end

    assign paddr = {sel_ppn, vaddr[OFF_W-1:0]};
    assign attr  = sel_attr;
endmodule

// File: rtl/region_mode_decode.sv
module region_mode_decode
    import region_xlate_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic [ATTR_W-1:0] attr,
    output mode_e             mode,
    output logic              fault
);
    mode_e lane_f, lane_l, lane_s;

    assign lane_f = fetch_mode(attr);
    assign lane_l = load_mode(attr);
    assign lane_s = store_mode(attr);

    always_comb begin
        case (kind_e'(kind))
            KIND_FETCH: mode = lane_f;
            KIND_LOAD:  mode = lane_l;
            KIND_STORE: mode = lane_s;
            default:    mode = MODE_FAULT;
        endcase
    end

    assign fault = (mode == MODE_FAULT);
endmodule

// File: rtl/region_xlate.sv
module region_xlate
    import region_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    output logic [ADDR_W-1:0] xl_paddr,
    output logic [MODE_W-1:0] xl_mode,
    output logic              xl_fault,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [IDX_W-1:0]  wr_ppn,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [IDX_W-1:0]  rd_vrn,
    output logic [IDX_W-1:0]  rd_ppn,
    output logic [ATTR_W-1:0] rd_attr
);
    localparam int NUM_ENT = 1 << IDX_W;

    logic [NUM_ENT-1:0][IDX_W-1:0]  ppn_q;
    logic [NUM_ENT-1:0][ATTR_W-1:0] attr_q;
    logic [ATTR_W-1:0]              look_attr;
    mode_e                          mode;

    region_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_ppn  (wr_ppn),
        .wr_attr (wr_attr),
        .ppn_q   (ppn_q),
        .attr_q  (attr_q)
    );

    region_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
        .vaddr    (req_vaddr),
        .ppn_tab  (ppn_q),
        .attr_tab (attr_q),
        .paddr    (xl_paddr),
        .attr     (look_attr)
    );

    region_mode_decode u_decode (
        .kind  (req_kind),
        .attr  (look_attr),
        .mode  (mode),
        .fault (xl_fault)
    );

    assign xl_mode = mode;

    // read port: virtual number is the fixed index itself
    assign rd_vrn  = rd_idx;
    assign rd_ppn  = ppn_q[rd_idx];
    assign rd_attr = attr_q[rd_idx];
endmodule

// File: rtl/region_xlate_chk.sv
module region_xlate_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] xl_paddr,
    input logic [3:0]        xl_mode,
    input logic              xl_fault,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [IDX_W-1:0]  wr_ppn,
    input logic [3:0]        wr_attr,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [IDX_W-1:0]  rd_vrn,
    input logic [IDX_W-1:0]  rd_ppn,
    input logic [3:0]        rd_attr
);
    localparam int OFF_W = ADDR_W - IDX_W;

    assert_reset_identity_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_ppn == rd_idx && rd_attr == 4'd2));

    assert_vrn_fixed_R2: assert property (@(posedge clk) disable iff (rst)
        rd_vrn == rd_idx);

    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (rst)
        xl_paddr[OFF_W-1:0] == req_vaddr[OFF_W-1:0]);

    assert_fetch_no_isolate_R4: assert property (@(posedge clk) disable iff (rst)
        req_kind == 2'd0 |-> (xl_mode != 4'd8 && xl_mode != 4'd5));

    assert_attr15_faults_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == req_vaddr[ADDR_W-1 -: IDX_W] && rd_attr == 4'hF) |-> xl_fault);

    assert_rsvd_kind_R7: assert property (@(posedge clk) disable iff (rst)
        req_kind == 2'd3 |-> (xl_fault && xl_mode == 4'd0));

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_idx != $past(wr_idx) ||
                   (rd_ppn == $past(wr_ppn) && rd_attr == $past(wr_attr))));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (rd_idx != $past(rd_idx) || ($stable(rd_ppn) && $stable(rd_attr))));
endmodule

bind region_xlate region_xlate_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_region_xlate.sv
`timescale 1ns/1ps
module sim_region_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [31:0] xl_paddr;
    logic [3:0]  xl_mode;
    logic        xl_fault;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [2:0]  wr_ppn = '0;
    logic [3:0]  wr_attr = '0;
    logic [2:0]  rd_idx = '0;
    logic [2:0]  rd_vrn, rd_ppn;
    logic [3:0]  rd_attr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    region_xlate u0 (
        .clk(clk), .rst(rst), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .xl_paddr(xl_paddr), .xl_mode(xl_mode), .xl_fault(xl_fault),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_ppn(wr_ppn), .wr_attr(wr_attr),
        .rd_idx(rd_idx), .rd_vrn(rd_vrn), .rd_ppn(rd_ppn), .rd_attr(rd_attr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected mode from the requirement tables
    function automatic logic [3:0] exp_mode(input logic [1:0] k, input logic [3:0] a);
        logic [3:0] m;
        m = 4'd0;
        if (k == 2'd0) begin
            if (a == 4'd2) m = 4'd3;
            else if (a == 4'd1 || a == 4'd3 || a == 4'd4 || a == 4'd5) m = 4'd1;
        end else if (k == 2'd1) begin
            if (a == 4'd0) m = 4'd2;
            else if (a == 4'd1 || a == 4'd4 || a == 4'd5) m = 4'd1;
            else if (a == 4'd2) m = 4'd4;
            else if (a == 4'd14) m = 4'd8;
        end else if (k == 2'd2) begin
            if (a == 4'd0 || a == 4'd1) m = 4'd5;
            else if (a == 4'd2) m = 4'd3;
            else if (a == 4'd4) m = 4'd6;
            else if (a == 4'd5) m = 4'd7;
            else if (a == 4'd14) m = 4'd8;
        end
        return m;
    endfunction

    task automatic do_write(input logic [2:0] idx, input logic [2:0] ppn, input logic [3:0] attr);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_ppn = ppn; wr_attr = attr;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic t_reset_state(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #1;
            chk(rd_ppn == 3'(i), req, "reset ppn", 32'(rd_ppn), 32'(i));
            chk(rd_attr == 4'd2, req, "reset attr", 32'(rd_attr), 32'd2);
            chk(rd_vrn == 3'(i), "R2", "fixed vrn", 32'(rd_vrn), 32'(i));
        end
    endtask

    task automatic t_identity();
        logic [31:0] va [4] = '{32'h0000_0000, 32'h3FFF_FFFC, 32'h9ABC_DEF0, 32'hFFFF_FFFF};
        for (int i = 0; i < 4; i++) begin
            req_vaddr = va[i]; req_kind = 2'd1;
            #1;
            chk(xl_paddr == va[i], "R3", "identity paddr", xl_paddr, va[i]);
            chk(xl_mode == 4'd4, "R5", "reset load mode", 32'(xl_mode), 32'd4);
            req_kind = 2'd0;
            #1;
            chk(xl_mode == 4'd3 && !xl_fault, "R4", "reset fetch mode", 32'(xl_mode), 32'd3);
        end
    endtask

    task automatic t_write_timing();
        rd_idx = 3'd3; req_vaddr = 32'h6123_4567; req_kind = 2'd2;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd3; wr_ppn = 3'd6; wr_attr = 4'd4;
        #1;
        chk(xl_paddr == 32'h6123_4567, "R8", "paddr before edge", xl_paddr, 32'h6123_4567);
        chk(rd_ppn == 3'd3, "R8", "read before edge", 32'(rd_ppn), 32'd3);
        chk(xl_mode == 4'd3, "R8", "mode before edge", 32'(xl_mode), 32'd3);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk(xl_paddr == 32'hC123_4567, "R8", "paddr after edge", xl_paddr, 32'hC123_4567);
        chk(xl_mode == 4'd6, "R8", "store mode after edge", 32'(xl_mode), 32'd6);
        chk(rd_ppn == 3'd6 && rd_attr == 4'd4, "R9", "read current", {rd_ppn, rd_attr}, {3'd6, 4'd4});
    endtask

    task automatic t_others_kept();
        for (int i = 0; i < 8; i++) begin
            if (i != 3) begin
                rd_idx = 3'(i);
                #1;
                chk(rd_ppn == 3'(i) && rd_attr == 4'd2, "R9", "untouched entry",
                    {rd_ppn, rd_attr}, {3'(i), 4'd2});
            end
        end
    endtask

    task automatic t_remap();
        do_write(3'd7, 3'd0, 4'd1);
        req_vaddr = 32'hE000_0010; req_kind = 2'd1;
        #1;
        chk(xl_paddr == 32'h0000_0010, "R2", "remapped region", xl_paddr, 32'h0000_0010);
        chk(xl_mode == 4'd1, "R5", "remapped attr", 32'(xl_mode), 32'd1);
        req_vaddr = 32'h0000_0010;
        #1;
        chk(xl_paddr == 32'h0000_0010 && xl_mode == 4'd4, "R2", "entry 0 still selected",
            {xl_paddr[31:4], xl_mode}, {28'h0000_001, 4'd4});
        rd_idx = 3'd7;
        #1;
        chk(rd_vrn == 3'd7, "R2", "vrn after remap", 32'(rd_vrn), 32'd7);
    endtask

    task automatic t_sweep(input logic [1:0] k, input string req);
        for (int a = 0; a < 16; a++) begin
            do_write(3'd5, 3'd1, 4'(a));
            req_vaddr = 32'hA0AB_C123; req_kind = k;
            #1;
            chk(xl_mode == exp_mode(k, 4'(a)), req, $sformatf("mode attr %0d", a),
                32'(xl_mode), 32'(exp_mode(k, 4'(a))));
            chk(xl_fault == (exp_mode(k, 4'(a)) == 4'd0), "R7", $sformatf("fault attr %0d", a),
                32'(xl_fault), 32'(exp_mode(k, 4'(a)) == 4'd0));
            chk(xl_paddr == 32'h20AB_C123, "R3", "swept paddr", xl_paddr, 32'h20AB_C123);
        end
    endtask

    task automatic t_reserved_kind();
        do_write(3'd5, 3'd1, 4'd1);
        req_vaddr = 32'hA000_0000; req_kind = 2'd3;
        #1;
        chk(xl_fault && xl_mode == 4'd0, "R7", "reserved kind", {xl_fault, xl_mode}, {1'b1, 4'd0});
    endtask

    task automatic t_reset_restore();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset_state("R10");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset_state("R1");
        t_identity();
        t_write_timing();
        t_others_kept();
        t_remap();
        t_sweep(2'd0, "R4");
        t_sweep(2'd1, "R5");
        t_sweep(2'd2, "R6");
        t_reserved_kind();
        t_reset_restore();
        finish_run();
    end
endmodule